// File: doc/BRIEF.md
# Multi-Source Set/Reset Latch Peripheral

This block is a set/reset latch whose set side and reset side can each be driven by any mix of five sources. The sources are an external input pin, two comparator results that arrive already synchronized, a periodic one-cycle tick made by an internal divider, and a software pulse. Software picks the sources for each side, the divider rate and the output enables through two 8-bit control registers on a small write/read bus. The latch drives a true output and a complement output. Each output has its own enable, and a global enable gates both.

The latch is a register on the system clock. Each rising edge combines the enabled sources into one set request and one reset request. A reset request always wins. When neither request is present the latch keeps its value. Typical uses are oscillators, one-shots and hysteretic control loops, where comparator events set and clear the latch.

Top module: `srl_top`

## Requirements
- R1: A synchronous active-high `rst` clears both control registers and the latch state. After reset, `q_out`, `qn_out` and both register reads are 0.
- R2: Writing with `bus_addr`=0 stores control word A and writing with `bus_addr`=1 stores control word B. `bus_rdata` returns the selected word combinationally. Bits 1:0 of word A always read as 0.
- R3: Writing 1 to word A bit 1 (software set) raises the set request for exactly the cycle after the write, and the latch holds 1 after the following edge. The bit then clears itself.
- R4: Writing 1 to word A bit 0 (software reset) raises the reset request for one cycle in the same way, which clears the latch.
- R5: When the set and reset requests are both high on an edge, the latch becomes 0.
- R6: The pin input `pin_in` requests set when word B bit 7 is 1 and requests reset when word B bit 3 is 1. While both bits are 0, the pin has no effect.
- R7: `cmp2_in` acts through word B bit 5 (set) and bit 1 (reset). `cmp1_in` acts through bit 4 (set) and bit 0 (reset). All of these inputs are active-high.
- R8: A free-running cycle counter cleared by reset produces a one-cycle tick every 2^(sel+2) cycles, where sel is word A bits 6:4 (4 to 512 cycles). The tick requests set only when word B bit 6 is 1 and requests reset only when word B bit 2 is 1.
- R9: With no set and no reset request, the latch holds its value.
- R10: `q_out` = global enable (word A bit 7) AND Q enable (bit 3) AND state. `qn_out` = global enable AND complement enable (bit 2) AND NOT state. A disabled output drives 0.
- R11: The latch keeps following its requests while the global enable is 0; only the outputs are gated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for the control registers |
| bus_addr | input | 1 | Register select: 0 = word A, 1 = word B |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| pin_in | input | 1 | External source input |
| cmp1_in | input | 1 | Synchronized comparator 1 result |
| cmp2_in | input | 1 | Synchronized comparator 2 result |
| q_out | output | 1 | Gated latch output |
| qn_out | output | 1 | Gated complement output |

## Verification
The assertions assume that `pin_in`, `cmp1_in` and `cmp2_in` are already synchronous to `clk` and change only between edges. They also assume `rst` is held high from time zero until after the first edge. The bench drives every input, including the bus, only on falling edges, so each input is stable across the rising edge that samples it. The bench also asserts reset before any other stimulus. Divider codes are changed freely while the counter runs. This is safe for the assertions because the tick period is never shorter than four cycles under any code.

// File: rtl/srl_pkg.sv
package srl_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 3;
  localparam int CNT_W  = (1 << SEL_W) - 1 + 2;
  localparam int NSRC   = 4;
  localparam int NSIDE  = 2;

  typedef struct packed {
    logic             glob_en;
    logic [SEL_W-1:0] div_sel;
    logic             q_en;
    logic             qn_en;
    logic             sw_set;
    logic             sw_clr;
  } ctl_a_t;

  typedef struct packed {
    logic pin_set;
    logic tick_set;
    logic c2_set;
    logic c1_set;
    logic pin_clr;
    logic tick_clr;
    logic c2_clr;
    logic c1_clr;
  } ctl_b_t;

  function automatic logic [CNT_W-1:0] tick_mask(input logic [SEL_W-1:0] sel);
    logic [SEL_W:0] sh;
    sh = {1'b0, sel} + (SEL_W+1)'(2);
    return (CNT_W'(1) << sh) - CNT_W'(1);
  endfunction

  function automatic logic side_request(input logic [NSRC-1:0] src,
                                        input logic [NSRC-1:0] en,
                                        input logic sw);
    return (|(src & en)) | sw;
  endfunction

  function automatic logic next_state(input logic cur, input logic s, input logic r);
    if (r)      return 1'b0;
    else if (s) return 1'b1;
    else        return cur;
  endfunction
endpackage

// File: rtl/srl_regs.sv
module srl_regs
  import srl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output ctl_a_t            ctl_a,
  output ctl_b_t            ctl_b,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_a <= '0;
      ctl_b <= '0;
    end else begin
      ctl_a.sw_set <= 1'b0;
      ctl_a.sw_clr <= 1'b0;
      if (wr) begin
        if (!addr) ctl_a <= ctl_a_t'(wdata);
        else       ctl_b <= ctl_b_t'(wdata);
      end
    end
  end

  always_comb begin
    if (addr) rdata = DATA_W'(ctl_b);
    else      rdata = {DATA_W'(ctl_a) & ~DATA_W'(3)};
  end
endmodule

// File: rtl/srl_tick_gen.sv
module srl_tick_gen
  import srl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + CNT_W'(1);
  end

  assign mask = tick_mask(sel);
  assign tick = ((cnt & mask) == mask);
endmodule

// File: rtl/srl_core.sv
module srl_core
  import srl_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  ctl_b_t ctl_b,
  input  logic   sw_set,
  input  logic   sw_clr,
  input  logic   pin,
  input  logic   cmp1,
  input  logic   cmp2,
  input  logic   tick,
  output logic   eff_set,
  output logic   eff_clr,
  output logic   state
);
  logic [NSRC-1:0]             src;
  logic [NSIDE-1:0][NSRC-1:0]  en;
  logic [NSIDE-1:0]            sw;
  logic [NSIDE-1:0]            req;

  assign src   = {pin, tick, cmp2, cmp1};
  assign en[0] = {ctl_b.pin_set, ctl_b.tick_set, ctl_b.c2_set, ctl_b.c1_set};
  assign en[1] = {ctl_b.pin_clr, ctl_b.tick_clr, ctl_b.c2_clr, ctl_b.c1_clr};
  assign sw    = {sw_clr, sw_set};

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    assign req[g] = side_request(src, en[g], sw[g]);
  end

  assign eff_set = req[0];
  assign eff_clr = req[1];

  always_ff @(posedge clk) begin
    if (rst) state <= 1'b0;
    else     state <= next_state(state, eff_set, eff_clr);
  end
endmodule

// File: rtl/srl_top.sv
module srl_top
  import srl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pin_in,
  input  logic              cmp1_in,
  input  logic              cmp2_in,
  output logic              q_out,
  output logic              qn_out
);
  ctl_a_t ctl_a;
  ctl_b_t ctl_b;
  logic   tick_pulse;
  logic   eff_set;
  logic   eff_clr;
  logic   latch_q;
  logic   glob_en;

  srl_regs u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .ctl_a (ctl_a),
    .ctl_b (ctl_b),
    .rdata (bus_rdata)
  );

  srl_tick_gen u_tick (
    .clk  (clk),
    .rst  (rst),
    .sel  (ctl_a.div_sel),
    .tick (tick_pulse)
  );

  srl_core u_core (
    .clk     (clk),
    .rst     (rst),
    .ctl_b   (ctl_b),
    .sw_set  (ctl_a.sw_set),
    .sw_clr  (ctl_a.sw_clr),
    .pin     (pin_in),
    .cmp1    (cmp1_in),
    .cmp2    (cmp2_in),
    .tick    (tick_pulse),
    .eff_set (eff_set),
    .eff_clr (eff_clr),
    .state   (latch_q)
  );

  assign glob_en = ctl_a.glob_en;
  assign q_out   = glob_en & ctl_a.q_en  &  latch_q;
  assign qn_out  = glob_en & ctl_a.qn_en & ~latch_q;
endmodule

// File: rtl/srl_checker.sv
module srl_checker (
  input logic       clk,
  input logic       rst,
  input logic       eff_set,
  input logic       eff_clr,
  input logic       latch_q,
  input logic       tick_pulse,
  input logic       glob_en,
  input logic       q_out,
  input logic       qn_out,
  input logic       bus_addr,
  input logic [7:0] bus_rdata
);
  assert_reset_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (eff_set && eff_clr) |=> !latch_q);

  assert_set_applies_R6: assert property (@(posedge clk) disable iff (rst)
    (eff_set && !eff_clr) |=> latch_q);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!eff_set && !eff_clr) |=> $stable(latch_q));

  assert_tick_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    tick_pulse |=> !tick_pulse);

  assert_gate_off_R10: assert property (@(posedge clk) disable iff (rst)
    !glob_en |-> (!q_out && !qn_out));

  assert_outputs_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(q_out && qn_out));

  assert_sw_bits_read_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !bus_addr |-> (bus_rdata[1:0] == 2'b00));
endmodule

bind srl_top srl_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .eff_set    (eff_set),
  .eff_clr    (eff_clr),
  .latch_q    (latch_q),
  .tick_pulse (tick_pulse),
  .glob_en    (glob_en),
  .q_out      (q_out),
  .qn_out     (qn_out),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata)
);

// File: tb/srl_top_tb.sv
module srl_top_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       pin_in = 1'b0;
  logic       cmp1_in = 1'b0;
  logic       cmp2_in = 1'b0;
  logic       q_out;
  logic       qn_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  srl_top u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .cmp1_in(cmp1_in), .cmp2_in(cmp2_in), .q_out(q_out), .qn_out(qn_out)
  );

  // behavioural reference model
  int   m_cnt = 0;
  logic [7:0] m_a = 0, m_b = 0;
  bit   m_sws = 0, m_swc = 0, m_state = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int period; bit tk, s, r;
    #(CLK_P/4);
    if (rst) begin
      m_cnt = 0; m_a = 0; m_b = 0; m_sws = 0; m_swc = 0; m_state = 0;
    end else begin
      period = 1 << (int'(m_a[6:4]) + 2);
      tk = (m_cnt % period) == period - 1;
      s = (pin_in & m_b[7]) | (tk & m_b[6]) | (cmp2_in & m_b[5]) | (cmp1_in & m_b[4]) | m_sws;
      r = (pin_in & m_b[3]) | (tk & m_b[2]) | (cmp2_in & m_b[1]) | (cmp1_in & m_b[0]) | m_swc;
      if (r) m_state = 0; else if (s) m_state = 1;
      m_cnt = (m_cnt + 1) % 512;
      m_sws = 0; m_swc = 0;
      if (bus_wr) begin
        if (!bus_addr) begin m_a = bus_wdata & 8'hFC; m_sws = bus_wdata[1]; m_swc = bus_wdata[0]; end
        else m_b = bus_wdata;
      end
    end
    if (!done) begin
      check("R10 model q_out", q_out, m_a[7] & m_a[3] & m_state);
      check("R10 model qn_out", qn_out, m_a[7] & m_a[2] & ~m_state);
      check("R2 model rdata", bus_rdata, bus_addr ? m_b : m_a);
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic measure(output int gap);
    logic prev; int n;
    prev = q_out;
    forever begin @(negedge clk); if (prev && !q_out) break; prev = q_out; end
    n = 0; prev = q_out;
    forever begin @(negedge clk); n++; if (prev && !q_out) break; prev = q_out; end
    gap = n;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P*150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [7:0] d; int gap, falls; logic prev;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 q_out", q_out, 0);
    check("R1 qn_out", qn_out, 0);
    rd(0, d); check("R1 word A", d, 0);
    rd(1, d); check("R1 word B", d, 0);

    // R2 register storage
    wr(1, 8'hA5); rd(1, d); check("R2 word B readback", d, 8'hA5);
    wr(1, 8'h00);
    wr(0, 8'h8C); rd(0, d); check("R2 word A readback", d, 8'h8C);
    check("R10 qn with state 0", qn_out, 1);

    // R3 software set
    wr(0, 8'h8E);
    rd(0, d); check("R3 sw bit reads 0", d, 8'h8C);
    check("R3 q after sw set", q_out, 1);
    repeat (5) @(negedge clk);
    check("R9 hold after set", q_out, 1);

    // R4 software reset
    wr(0, 8'h8D); @(negedge clk);
    check("R4 q after sw reset", q_out, 0);
    check("R4 qn after sw reset", qn_out, 1);

    // R5 dominance
    wr(0, 8'h8E); @(negedge clk);
    wr(0, 8'h8F); @(negedge clk);
    check("R5 both sw pulses", q_out, 0);
    cmp1_in = 1; cmp2_in = 1; wr(1, 8'h21); @(negedge clk);
    check("R5 cmp set vs cmp reset", q_out, 0);
    wr(1, 8'h00); cmp1_in = 0; cmp2_in = 0;

    // R6 pin
    pin_in = 1; repeat (3) @(negedge clk);
    check("R6 pin ignored when disabled", q_out, 0);
    wr(1, 8'h80); @(negedge clk);
    check("R6 pin set", q_out, 1);
    wr(1, 8'h08); @(negedge clk);
    check("R6 pin reset", q_out, 0);
    wr(1, 8'h00); pin_in = 0;

    // R7 comparators
    wr(1, 8'h20); cmp2_in = 1; @(negedge clk); @(negedge clk);
    check("R7 cmp2 set", q_out, 1);
    cmp2_in = 0; wr(1, 8'h01); cmp1_in = 1; @(negedge clk); @(negedge clk);
    check("R7 cmp1 reset", q_out, 0);
    wr(1, 8'h10); @(negedge clk);
    check("R7 cmp1 set", q_out, 1);
    cmp1_in = 0; wr(1, 8'h02); cmp2_in = 1; @(negedge clk); @(negedge clk);
    check("R7 cmp2 reset", q_out, 0);
    cmp2_in = 0; wr(1, 8'h00);

    // R8 tick disabled has no effect
    wr(1, 8'h10); cmp1_in = 1; @(negedge clk);
    falls = 0; prev = q_out;
    repeat (40) begin @(negedge clk); if (prev && !q_out) falls++; prev = q_out; end
    check("R8 tick ignored without enable", falls, 0);

    // R8 tick period for every code
    wr(1, 8'h14);
    for (int c = 0; c < 8; c++) begin
      wr(0, 8'h88 | 8'(c << 4));
      measure(gap);
      check($sformatf("R8 period code %0d", c), gap, 1 << (c + 2));
    end
    wr(1, 8'h00); cmp1_in = 0;

    // R10 gating
    wr(0, 8'h8E); @(negedge clk);
    wr(0, 8'h84); check("R10 q disabled by its enable", q_out, 0);
    check("R10 qn low while set", qn_out, 0);
    wr(0, 8'h0C); check("R10 global off q", q_out, 0);
    check("R10 global off qn", qn_out, 0);

    // R11 latch tracks while globally disabled
    wr(0, 8'h0D); @(negedge clk);
    wr(0, 8'h8C);
    check("R11 state cleared while disabled", qn_out, 1);
    check("R11 q after re-enable", q_out, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule